// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block runs on the always-on slow clock. It turns several reset sources into separate active-low reset outputs for the processor, the processor-side peripherals, the coprocessor and the board-level reset pin. The sources are an exit from backup mode requested by the supply controller, a fault from the watchdog, and software commands written through a small keyed register port. Processor reset always lasts two cycles longer than peripheral reset, so that the processor starts only once its peripherals are out of reset. A status field records the cause of the last reset.

A watchdog fault is programmable. It can reset only the processor, or it can reset the processor and the peripherals and also pull the reset pin low for a programmable power-of-two length. The block samples the pin back through a synchronizer to report user-reset events. It blanks that report while it drives the pin itself and for a short time afterwards. The coprocessor is held in reset whenever its enable bit in the mode register is cleared.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While rst_ni is low, proc_rst_no, peri_rst_no and cp_rst_no are low, ext_rst_no is high and rst_type_o is 0. After release, peri_rst_no and cp_rst_no go high after the first clock edge and proc_rst_no goes high two cycles later.
- R2: While bkup_req_i is sampled high, proc_rst_no, peri_rst_no and cp_rst_no are low from the next cycle, rst_type_o becomes 1 and any external pin drive stops. After bkup_req_i falls, peri_rst_no and cp_rst_no are released at the next edge and proc_rst_no two cycles later.
- R3: A wdt_fault_i pulse with wdt_rst_en_i=1 and wdt_proc_only_i=0, accepted while idle, drives peri_rst_no low for 3 cycles and proc_rst_no low for 5 cycles, starting in the next cycle. It sets rst_type_o to 2.
- R4: The fault of R3 also drives ext_rst_no low for 2^(L+1) cycles, starting in the same cycle as peri_rst_no. L is the external-length field in effect when the fault is accepted.
- R5: A fault with wdt_proc_only_i=1 drives only proc_rst_no low, for 5 cycles. peri_rst_no and ext_rst_no stay high, and rst_type_o becomes 2.
- R6: With wdt_rst_en_i=0 a fault changes no output.
- R7: A write with reg_sel_i=0 and key 0xA5 is a command. Bit 0 drives proc_rst_no low for 5 cycles and bit 1 drives peri_rst_no low for 3 cycles. A command with either bit set sets rst_type_o to 3, and cp_rst_no is not touched.
- R8: A write whose reg_key_i is not 0xA5 is ignored by both registers.
- R9: A write with reg_sel_i=1 and key 0xA5 sets the mode register. Bits 3:0 hold L and bit 4 is the coprocessor enable. cp_rst_no follows that enable from the next cycle. The reset values are L=0 and enable=1.
- R10: A fault or command that arrives while a reset sequence is still running is ignored. When a fault and a command arrive in the same idle cycle, the fault wins.
- R11: usr_rst_o pulses for one cycle when a falling edge of nrst_pin_i has passed through a two-stage synchronizer. The pulse is suppressed while ext_rst_no is low and for 3 cycles after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| bkup_req_i | input | 1 | Core reset request from the supply controller on backup exit |
| wdt_fault_i | input | 1 | Watchdog fault pulse |
| wdt_rst_en_i | input | 1 | Watchdog fault may cause a reset |
| wdt_proc_only_i | input | 1 | Watchdog fault resets the processor only |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = command register, 1 = mode register |
| reg_key_i | input | 8 | Write key, must be 0xA5 |
| reg_wdata_i | input | 8 | Write data |
| nrst_pin_i | input | 1 | Sampled level of the reset pin |
| proc_rst_no | output | 1 | Processor and watchdog reset |
| peri_rst_no | output | 1 | Processor-side peripheral reset |
| cp_rst_no | output | 1 | Coprocessor reset |
| ext_rst_no | output | 1 | Reset pin drive, low = pull down |
| usr_rst_o | output | 1 | User-reset event pulse |
| rst_type_o | output | 3 | Cause of last reset: 0 general, 1 backup, 2 watchdog, 3 software |

## Verification
Two pairs of functions can fall in the same cycle. A watchdog fault and a keyed command can arrive together at an idle controller. The bench pulses both in one cycle and expects the watchdog pattern: rst_type_o=2, peripheral reset and pin drive, and no trace of the command. In the second pair, the pin is looped back through the bench as a wired AND, so the block's own pin drive and the user-reset sampler act at the same time; a watchdog pin drive must then produce no usr_rst_o pulse. A behavioural reference model computes every output on every clock, and directed counters check pulse lengths and cause codes.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BKUP, ST_HOLD, ST_START} seq_st_e;

  typedef struct packed {
    logic proc;
    logic peri;
  } rst_mask_t;

  localparam logic [2:0] RT_GENERAL  = 3'd0;
  localparam logic [2:0] RT_BACKUP   = 3'd1;
  localparam logic [2:0] RT_WATCHDOG = 3'd2;
  localparam logic [2:0] RT_SOFT     = 3'd3;
  localparam logic [7:0] WR_KEY      = 8'hA5;
endpackage

// File: rtl/rst_seq_regs.sv
module rst_seq_regs
  import rst_seq_pkg::*;
#(
  parameter int EXT_LEN_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 sel_i,
  input  logic [7:0]           key_i,
  input  logic [7:0]           wdata_i,
  output logic                 sw_req_o,
  output rst_mask_t            sw_mask_o,
  output logic [EXT_LEN_W-1:0] ext_len_o,
  output logic                 cp_en_o
);
  logic key_ok;
  logic mode_wr;

  assign key_ok    = (key_i == WR_KEY);
  assign mode_wr   = we_i & sel_i & key_ok;
  assign sw_mask_o = '{proc: wdata_i[0], peri: wdata_i[1]};
  assign sw_req_o  = we_i & ~sel_i & key_ok & (wdata_i[0] | wdata_i[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_len_o <= '0;
      cp_en_o   <= 1'b1;
    end else if (mode_wr) begin
      ext_len_o <= wdata_i[EXT_LEN_W-1:0];
      cp_en_o   <= wdata_i[4];
    end
  end

  // R8
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && key_i != WR_KEY) |=> ($stable(ext_len_o) && $stable(cp_en_o)));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int HOLD_CYC  = 3,
  parameter int START_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bkup_req_i,
  input  logic       wdt_fault_i,
  input  logic       wdt_rst_en_i,
  input  logic       wdt_proc_only_i,
  input  logic       sw_req_i,
  input  rst_mask_t  sw_mask_i,
  output logic       proc_rst_no,
  output logic       peri_rst_no,
  output logic       bkup_act_o,
  output logic       ext_load_o,
  output logic [2:0] rst_type_o
);
  localparam int MAX_CYC = (HOLD_CYC > START_CYC) ? HOLD_CYC : START_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_st_e          state_q;
  rst_mask_t        mask_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle;
  logic             wd_hit;

  assign idle       = (state_q == ST_IDLE);
  assign wd_hit     = idle & ~bkup_req_i & wdt_fault_i & wdt_rst_en_i;
  assign ext_load_o = wd_hit & ~wdt_proc_only_i;
  assign bkup_act_o = (state_q == ST_BKUP);

  assign proc_rst_no = ~(bkup_act_o |
                        (((state_q == ST_HOLD) | (state_q == ST_START)) & mask_q.proc));
  assign peri_rst_no = ~(bkup_act_o | ((state_q == ST_HOLD) & mask_q.peri));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_BKUP;
      mask_q     <= '{proc: 1'b1, peri: 1'b1};
      cnt_q      <= '0;
      rst_type_o <= RT_GENERAL;
    end else if (bkup_req_i) begin
      state_q    <= ST_BKUP;
      mask_q     <= '{proc: 1'b1, peri: 1'b1};
      cnt_q      <= '0;
      rst_type_o <= RT_BACKUP;
    end else begin
      unique case (state_q)
        ST_BKUP: begin
          state_q <= ST_START;
          cnt_q   <= CNT_W'(START_CYC - 1);
        end
        ST_IDLE: begin
          if (wd_hit) begin
            mask_q     <= '{proc: 1'b1, peri: ~wdt_proc_only_i};
            state_q    <= ST_HOLD;
            cnt_q      <= CNT_W'(HOLD_CYC - 1);
            rst_type_o <= RT_WATCHDOG;
          end else if (sw_req_i) begin
            mask_q     <= sw_mask_i;
            state_q    <= ST_HOLD;
            cnt_q      <= CNT_W'(HOLD_CYC - 1);
            rst_type_o <= RT_SOFT;
          end
        end
        ST_HOLD: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (mask_q.proc) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(START_CYC - 1);
          end else state_q <= ST_IDLE;
        end
        ST_START: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  bkup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkup_req_i |=> (!proc_rst_no && !peri_rst_no && rst_type_o == RT_BACKUP));
  // R6
  wd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && wdt_fault_i && !wdt_rst_en_i && !sw_req_i && !bkup_req_i)
      |=> (proc_rst_no && peri_rst_no && $stable(rst_type_o)));
  // R3
  proc_after_peri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(proc_rst_no) |-> ($past(peri_rst_no) && $past(peri_rst_no, 2)));
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !bkup_act_o && !bkup_req_i) |=> $stable(rst_type_o));
endmodule

// File: rtl/rst_seq_pin.sv
module rst_seq_pin #(
  parameter int EXT_LEN_W = 4,
  parameter int BLANK_CYC = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 clr_i,
  input  logic [EXT_LEN_W-1:0] len_i,
  input  logic                 nrst_pin_i,
  output logic                 ext_rst_no,
  output logic                 usr_rst_o
);
  localparam int CNT_W = (1 << EXT_LEN_W) + 1;
  localparam int BLK_W = $clog2(BLANK_CYC + 1);

  logic [CNT_W-1:0]   ext_cnt_q;
  logic [EXT_LEN_W:0] shamt;
  logic [CNT_W-1:0]   load_val;
  logic [2:0]         sync_q;
  logic [BLK_W-1:0]   blank_q;
  logic               blank_act;
  logic               fall;

  assign shamt      = {1'b0, len_i} + (EXT_LEN_W+1)'(1);
  assign load_val   = CNT_W'(1) << shamt;
  assign ext_rst_no = (ext_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_cnt_q <= '0;
    else if (clr_i) ext_cnt_q <= '0;
    else if (load_i) ext_cnt_q <= load_val;
    else if (ext_cnt_q != '0) ext_cnt_q <= ext_cnt_q - 1'b1;
  end

  // sync_q[0..1] synchronize, sync_q[2] is the previous synchronized level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 3'b111;
      blank_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], nrst_pin_i};
      if (!ext_rst_no) blank_q <= BLK_W'(BLANK_CYC);
      else if (blank_q != '0) blank_q <= blank_q - 1'b1;
    end
  end

  assign blank_act = ~ext_rst_no | (blank_q != '0);
  assign fall      = sync_q[2] & ~sync_q[1];
  assign usr_rst_o = fall & ~blank_act;

  // R4
  ext_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> !ext_rst_no);
  // R11
  usr_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_rst_o |-> ext_rst_no);
  // R11
  usr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_rst_o |=> !usr_rst_o);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int EXT_LEN_W = 4,
  parameter int HOLD_CYC  = 3,
  parameter int START_CYC = 2,
  parameter int BLANK_CYC = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bkup_req_i,
  input  logic       wdt_fault_i,
  input  logic       wdt_rst_en_i,
  input  logic       wdt_proc_only_i,
  input  logic       reg_we_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_key_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       nrst_pin_i,
  output logic       proc_rst_no,
  output logic       peri_rst_no,
  output logic       cp_rst_no,
  output logic       ext_rst_no,
  output logic       usr_rst_o,
  output logic [2:0] rst_type_o
);
  logic                 sw_req;
  rst_mask_t            sw_mask;
  logic [EXT_LEN_W-1:0] ext_len;
  logic                 cp_en;
  logic                 bkup_act;
  logic                 ext_load;

  rst_seq_regs #(.EXT_LEN_W(EXT_LEN_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .key_i    (reg_key_i),
    .wdata_i  (reg_wdata_i),
    .sw_req_o (sw_req),
    .sw_mask_o(sw_mask),
    .ext_len_o(ext_len),
    .cp_en_o  (cp_en)
  );

  rst_seq_fsm #(.HOLD_CYC(HOLD_CYC), .START_CYC(START_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .bkup_req_i, .wdt_fault_i, .wdt_rst_en_i, .wdt_proc_only_i,
    .sw_req_i   (sw_req),
    .sw_mask_i  (sw_mask),
    .proc_rst_no, .peri_rst_no,
    .bkup_act_o (bkup_act),
    .ext_load_o (ext_load),
    .rst_type_o
  );

  rst_seq_pin #(.EXT_LEN_W(EXT_LEN_W), .BLANK_CYC(BLANK_CYC)) u_pin (
    .clk_i, .rst_ni,
    .load_i   (ext_load),
    .clr_i    (bkup_req_i),
    .len_i    (ext_len),
    .nrst_pin_i,
    .ext_rst_no,
    .usr_rst_o
  );

  assign cp_rst_no = cp_en & ~bkup_act;

  // R9
  cp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i && reg_key_i == WR_KEY && !bkup_req_i)
      |=> (cp_rst_no == $past(reg_wdata_i[4])));
endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bkup_req = 0, wd_fault = 0, wd_en = 1, wd_po = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_key = 0, reg_wdata = 0;
  logic tb_pin = 1'b1;
  logic proc_rst_no, peri_rst_no, cp_rst_no, ext_rst_no, usr_rst;
  logic [2:0] rst_type;
  wire nrst_pin = ext_rst_no & tb_pin;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bkup_req_i(bkup_req), .wdt_fault_i(wd_fault),
    .wdt_rst_en_i(wd_en), .wdt_proc_only_i(wd_po), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_key_i(reg_key), .reg_wdata_i(reg_wdata), .nrst_pin_i(nrst_pin),
    .proc_rst_no(proc_rst_no), .peri_rst_no(peri_rst_no), .cp_rst_no(cp_rst_no),
    .ext_rst_no(ext_rst_no), .usr_rst_o(usr_rst), .rst_type_o(rst_type)
  );

  // reference model: remaining-low timers
  int m_bk, m_proc, m_peri, m_ext, m_blank, m_type, m_len, m_cpen;
  bit s0, s1, s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bk = 1; m_proc = 0; m_peri = 0; m_ext = 0; m_blank = 0;
      m_type = 0; m_len = 0; m_cpen = 1; s0 = 1; s1 = 1; s2 = 1;
    end else begin
      automatic bit idle  = (m_bk == 0 && m_proc == 0 && m_peri == 0);
      automatic bit keyok = (reg_key == 8'hA5);
      automatic bit pinv  = (m_ext > 0) ? 1'b0 : tb_pin;
      if (m_ext > 0) m_blank = 3; else if (m_blank > 0) m_blank--;
      s2 = s1; s1 = s0; s0 = pinv;
      if (bkup_req) begin
        m_bk = 1; m_proc = 0; m_peri = 0; m_ext = 0; m_type = 1;
      end else begin
        if (m_ext > 0) m_ext--;
        if (m_bk == 1) begin
          m_bk = 0; m_proc = 2;
        end else if (idle) begin
          if (wd_fault && wd_en) begin
            m_type = 2; m_proc = 5; m_peri = wd_po ? 0 : 3;
            if (!wd_po) m_ext = 1 << (m_len + 1);
          end else if (reg_we && !reg_sel && keyok && (reg_wdata[0] || reg_wdata[1])) begin
            m_type = 3;
            m_proc = reg_wdata[0] ? 5 : 0;
            m_peri = reg_wdata[1] ? 3 : 0;
          end
        end else begin
          if (m_proc > 0) m_proc--;
          if (m_peri > 0) m_peri--;
        end
      end
      if (reg_we && reg_sel && keyok) begin
        m_len = reg_wdata[3:0]; m_cpen = reg_wdata[4];
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int ext_low_cnt = 0, usr_cnt = 0, peri_low_cnt = 0, proc_low_cnt = 0;

  always @(negedge clk) begin
    chk("R1 R3 R5 R7 proc_rst_no", proc_rst_no, !(m_bk == 1 || m_proc > 0));
    chk("R1 R2 R3 R7 peri_rst_no", peri_rst_no, !(m_bk == 1 || m_peri > 0));
    chk("R2 R9 cp_rst_no", cp_rst_no, !(m_bk == 1 || m_cpen == 0));
    chk("R4 ext_rst_no", ext_rst_no, !(m_ext > 0));
    chk("R11 usr_rst_o", usr_rst, s2 && !s1 && !(m_ext > 0 || m_blank > 0));
    chk("R2 R3 R7 rst_type_o", rst_type, m_type);
    if (!ext_rst_no) ext_low_cnt++;
    if (usr_rst) usr_cnt++;
    if (!peri_rst_no) peri_low_cnt++;
    if (!proc_rst_no) proc_low_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    ext_low_cnt = 0; usr_cnt = 0; peri_low_cnt = 0; proc_low_cnt = 0;
  endtask

  task automatic wr(input bit sel, input logic [7:0] key, input logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_key = key; reg_wdata = d;
    cyc(1);
    reg_we = 0; reg_key = 0;
  endtask

  task automatic fault(input bit po);
    wd_po = po; wd_fault = 1;
    cyc(1);
    wd_fault = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 proc in reset", proc_rst_no, 0);
    chk("R1 type in reset", rst_type, 0);
    chk("R1 ext in reset", ext_rst_no, 1);
    rst_n = 1;
    cyc(1);
    chk("R1 peri released", peri_rst_no, 1);
    chk("R1 proc still held", proc_rst_no, 0);
    cyc(2);
    chk("R1 proc released", proc_rst_no, 1);

    // R9 length 2, coprocessor enabled
    wr(1, 8'hA5, 8'h12);
    cyc(2);
    chk("R9 cp enabled", cp_rst_no, 1);

    // R3/R4 full watchdog reset
    clr_cnt();
    fault(0);
    cyc(12);
    chk("R4 ext low length len=2", ext_low_cnt, 8);
    chk("R3 peri low length", peri_low_cnt, 3);
    chk("R3 proc low length", proc_low_cnt, 5);
    chk("R3 type watchdog", rst_type, 2);
    chk("R11 no usr on own drive", usr_cnt, 0);

    // R5 processor only
    wr(0, 8'hA5, 8'h02); cyc(5);
    chk("R7 type soft", rst_type, 3);
    clr_cnt();
    fault(1);
    cyc(8);
    chk("R5 proc low", proc_low_cnt, 5);
    chk("R5 peri untouched", peri_low_cnt, 0);
    chk("R5 ext untouched", ext_low_cnt, 0);
    chk("R5 type", rst_type, 2);

    // R6 disabled fault
    clr_cnt(); wd_en = 0;
    fault(0);
    cyc(6);
    chk("R6 no proc", proc_low_cnt, 0);
    chk("R6 type kept", rst_type, 2);
    wd_en = 1;

    // R7 commands
    clr_cnt();
    wr(0, 8'hA5, 8'h03); cyc(7);
    chk("R7 both proc", proc_low_cnt, 5);
    chk("R7 both peri", peri_low_cnt, 3);
    chk("R7 cp untouched", cp_rst_no, 1);
    clr_cnt();
    wr(0, 8'hA5, 8'h01); cyc(7);
    chk("R7 proc only", proc_low_cnt, 5);
    chk("R7 no peri", peri_low_cnt, 0);

    // R8 bad key
    clr_cnt();
    wr(0, 8'h5A, 8'h03); wr(1, 8'hA4, 8'h00); cyc(6);
    chk("R8 bad cmd", proc_low_cnt, 0);
    chk("R8 bad mode cp", cp_rst_no, 1);

    // R9 coprocessor off/on
    wr(1, 8'hA5, 8'h00);
    chk("R9 cp held", cp_rst_no, 0);
    wr(1, 8'hA5, 8'h10);
    chk("R9 cp released", cp_rst_no, 1);

    // R4 boundary len=0
    clr_cnt();
    fault(0); cyc(8);
    chk("R4 ext len=0", ext_low_cnt, 2);

    // R10 same cycle fault and command: fault wins
    clr_cnt();
    wd_po = 0; wd_fault = 1; reg_we = 1; reg_sel = 0; reg_key = 8'hA5; reg_wdata = 8'h01;
    cyc(1);
    wd_fault = 0; reg_we = 0;
    cyc(1);
    chk("R10 fault wins type", rst_type, 2);
    chk("R10 fault wins peri", peri_rst_no, 0);
    // R10 command during sequence ignored
    wr(0, 8'hA5, 8'h03);
    chk("R10 busy cmd ignored", rst_type, 2);
    cyc(8);
    chk("R10 proc low once", proc_low_cnt, 5);

    // R4 longer length then R2 backup cancels drive
    wr(1, 8'hA5, 8'h15);
    clr_cnt();
    fault(0); cyc(10);
    bkup_req = 1; cyc(3);
    chk("R2 proc held", proc_rst_no, 0);
    chk("R2 cp held", cp_rst_no, 0);
    chk("R2 type backup", rst_type, 1);
    chk("R2 ext dropped", ext_rst_no, 1);
    bkup_req = 0; cyc(1);
    chk("R2 peri released", peri_rst_no, 1);
    chk("R2 proc after", proc_rst_no, 0);
    cyc(2);
    chk("R2 proc released", proc_rst_no, 1);

    // R4 full 64-cycle drive
    clr_cnt();
    fault(0); cyc(70);
    chk("R4 ext len=5", ext_low_cnt, 64);

    // R11 external user press
    cyc(6); clr_cnt();
    tb_pin = 0; cyc(4); tb_pin = 1; cyc(6);
    chk("R11 one usr pulse", usr_cnt, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule